// File: doc/BRIEF.md
# Latched Input Change Monitor

This block watches a group of bidirectional open-drain port pins and reports any change of their level. Each pin first passes through a synchronizer chain. A snapshot register holds the level each pin had at a reference moment. Whenever a synchronized pin differs from its snapshot bit, that port's change flag latches. An interrupt request, brought out as an open-drain pull-down enable, latches with it.

The serial-interface controller drives the block with three strobes. One marks the acknowledge of the block's own slave address, together with the transfer direction. One marks a STOP condition. One marks a bus abort from the interface reset. At each address acknowledge the snapshot reloads from the pins, the flags clear and the interrupt releases. While a read transfer is open, changes are still flagged, but the interrupt stays released. A change seen during the read raises the interrupt once STOP arrives.

A fourth strobe comes from the port output register. It opens a short settle window. During that window the snapshot follows the pins, so the block's own output writes never count as input changes. The same window runs after power-up reset.

Top module: `chg_watch`

## Requirements
- R1: A level change on port p sets bit p of `flag_o`, and only that bit. The flag becomes visible after the third rising clock edge that follows the change. When no read transfer is open, `irq_pull_o` rises on the same edge.
- R2: A flag bit stays set after its pin returns to the old level. A two-cycle pulse on a pin therefore leaves its flag set until the next address acknowledge.
- R3: An address acknowledge clears all flags and releases `irq_pull_o` on the next edge. This holds for both directions. The acknowledge also reloads the snapshot from the synchronized pins, so a pin that stays at its new level is not flagged again.
- R4: A read transfer is open from an acknowledge with `ack_is_read_i`=1 until STOP or abort. While it is open, `irq_pull_o` stays 0, but changes still set their flags.
- R5: If any flag was set during an open read, `irq_pull_o` becomes 1 on the edge that samples `stop_i`. A read that saw no change leaves `irq_pull_o` at 0 after STOP.
- R6: `bus_abort_i` closes an open transfer without changing `flag_o` or `irq_pull_o`. An asserted interrupt stays asserted.
- R7: For SYNC_STAGES+2 cycles after `out_wr_i`, the snapshot follows the pins and no flag is set. A pin change made in the cycle after the strobe is therefore never flagged.
- R8: After power-up reset, `flag_o` is 0 and `irq_pull_o` is 0. The pin levels present while reset is released are taken as the snapshot and are not flagged.
- R9: `irq_pull_o`=1 means the interrupt line is driven low. A value of 0 means the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| pin_i | input | NPORT | Asynchronous pin levels |
| addr_ack_i | input | 1 | One-cycle strobe: own slave address acknowledged |
| ack_is_read_i | input | 1 | Direction qualifying `addr_ack_i` (1 = read) |
| stop_i | input | 1 | One-cycle strobe: STOP condition seen |
| bus_abort_i | input | 1 | One-cycle strobe: interface reset voided the transfer |
| out_wr_i | input | 1 | One-cycle strobe: port output register written |
| flag_o | output | NPORT | Latched per-port change flags |
| irq_pull_o | output | 1 | Interrupt pull-down enable (1 = drive low) |

## Verification
The bench uses the default eight ports and a two-stage synchronizer, which gives a flag latency of exactly three edges. With only eight ports, the bench can sweep every port in both edge directions. For each port it checks the flag, then the sticky behaviour after the pin returns. The read window, the STOP release and the abort are each exercised with and without a change during the transfer. The short settle span also makes the output-write window small enough to probe at its edge.

// File: rtl/chg_watch_pkg.sv
package chg_watch_pkg;

    typedef enum logic [1:0] {
        XFER_IDLE  = 2'd0,
        XFER_WRITE = 2'd1,
        XFER_READ  = 2'd2
    } xfer_e;

endpackage

// File: rtl/chg_watch_sync.sv
module chg_watch_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = d_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/chg_watch_hold.sv
module chg_watch_hold #(
    parameter int SPAN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(SPAN + 1);
    localparam logic [CW-1:0] SPAN_V = CW'(SPAN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)          cnt_d = SPAN_V;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= SPAN_V;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/chg_watch.sv
module chg_watch
    import chg_watch_pkg::*;
#(
    parameter int NPORT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] pin_i,
    input  logic             addr_ack_i,
    input  logic             ack_is_read_i,
    input  logic             stop_i,
    input  logic             bus_abort_i,
    input  logic             out_wr_i,
    output logic [NPORT-1:0] flag_o,
    output logic             irq_pull_o
);
    localparam int SETTLE = SYNC_STAGES + 2;

    typedef struct packed {
        logic [NPORT-1:0] snap;
        logic [NPORT-1:0] flags;
        logic             irq;
        logic             pend;
        xfer_e            xfer;
    } state_t;

    logic [NPORT-1:0] pin_s;
    logic             settling;
    logic [NPORT-1:0] diff;
    state_t           s_d, s_q;

    chg_watch_sync #(.WIDTH(NPORT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    chg_watch_hold #(.SPAN(SETTLE)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (out_wr_i),
        .busy_o (settling)
    );

    always_comb begin
        s_d  = s_q;
        diff = settling ? '0 : (pin_s ^ s_q.snap);
        if (settling) s_d.snap = pin_s;

        s_d.flags = s_q.flags | diff;
        if (|diff) begin
            if (s_q.xfer == XFER_READ) s_d.pend = 1'b1;
            else                       s_d.irq  = 1'b1;
        end

        if (stop_i) begin
            if (s_q.xfer == XFER_READ && (s_q.pend || (|diff))) s_d.irq = 1'b1;
            s_d.xfer = XFER_IDLE;
            s_d.pend = 1'b0;
        end

        if (bus_abort_i) begin
            s_d.xfer = XFER_IDLE;
            s_d.pend = 1'b0;
        end

        if (addr_ack_i) begin
            s_d.snap  = pin_s;
            s_d.flags = '0;
            s_d.irq   = 1'b0;
            s_d.pend  = 1'b0;
            s_d.xfer  = ack_is_read_i ? XFER_READ : XFER_WRITE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.snap  <= '0;
            s_q.flags <= '0;
            s_q.irq   <= 1'b0;
            s_q.pend  <= 1'b0;
            s_q.xfer  <= XFER_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o     = s_q.flags;
    assign irq_pull_o = s_q.irq;
endmodule

// File: rtl/chg_watch_chk.sv
module chg_watch_chk #(
    parameter int NPORT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_ack_i,
    input logic             ack_is_read_i,
    input logic             stop_i,
    input logic             bus_abort_i,
    input logic             out_wr_i,
    input logic [NPORT-1:0] flag_o,
    input logic             irq_pull_o
);
    localparam int SETTLE = SYNC_STAGES + 2;
    localparam int CW     = $clog2(SETTLE + 1);

    logic          rd_win;
    logic [CW-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_win  <= 1'b0;
            win_cnt <= CW'(SETTLE);
        end else begin
            if (addr_ack_i)                 rd_win <= ack_is_read_i;
            else if (stop_i || bus_abort_i) rd_win <= 1'b0;
            if (out_wr_i)                   win_cnt <= CW'(SETTLE);
            else if (win_cnt != 0)          win_cnt <= win_cnt - 1'b1;
        end
    end

    // R1: interrupt never stands without a flag
    a_r1_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_o |-> (|flag_o));

    // R2: flags only accumulate between acknowledges
    a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ack_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    // R3: acknowledge clears flags and interrupt
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_i |=> (flag_o == '0 && !irq_pull_o));

    // R4: no interrupt while a read is open
    a_r4_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win && !stop_i && !bus_abort_i) |=> !irq_pull_o);

    // R6: abort keeps an asserted interrupt
    a_r6_abort_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_abort_i && irq_pull_o && !addr_ack_i) |=> irq_pull_o);

    // R7: no new flags inside the settle window
    a_r7_settle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt != 0 && !addr_ack_i) |=> (flag_o == $past(flag_o)));
endmodule

bind chg_watch chg_watch_chk #(.NPORT(NPORT), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_ack_i    (addr_ack_i),
    .ack_is_read_i (ack_is_read_i),
    .stop_i        (stop_i),
    .bus_abort_i   (bus_abort_i),
    .out_wr_i      (out_wr_i),
    .flag_o        (flag_o),
    .irq_pull_o    (irq_pull_o)
);

// File: tb/chg_watch_bench.sv
module chg_watch_bench;
    localparam int NPORT = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPORT-1:0] pin_i = '0;
    logic             addr_ack_i = 1'b0;
    logic             ack_is_read_i = 1'b0;
    logic             stop_i = 1'b0;
    logic             bus_abort_i = 1'b0;
    logic             out_wr_i = 1'b0;
    logic [NPORT-1:0] flag_o;
    logic             irq_pull_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chg_watch #(.NPORT(NPORT), .SYNC_STAGES(2)) u_chg_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_i         (pin_i),
        .addr_ack_i    (addr_ack_i),
        .ack_is_read_i (ack_is_read_i),
        .stop_i        (stop_i),
        .bus_abort_i   (bus_abort_i),
        .out_wr_i      (out_wr_i),
        .flag_o        (flag_o),
        .irq_pull_o    (irq_pull_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic ack(bit rd);
        addr_ack_i = 1'b1;
        ack_is_read_i = rd;
        tick();
        addr_ack_i = 1'b0;
        ack_is_read_i = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        tick();
        stop_i = 1'b0;
    endtask

    initial begin
        // R8: reset with nonzero pins, no spurious flags
        pin_i = 8'hA5;
        tick(2);
        rst_n = 1'b1;
        chk("R8 flags at reset", 32'(flag_o), 32'h0);
        chk("R9 irq released at reset", 32'(irq_pull_o), 32'h0);
        tick(6);
        chk("R8 flags after settle", 32'(flag_o), 32'h0);
        chk("R8 irq after settle", 32'(irq_pull_o), 32'h0);

        // R1/R2 sweep: every port, both directions
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int p = 0; p < NPORT; p++) begin
                pin_i = (lvl != 0) ? 8'hFF : 8'h00;
                tick(4);
                ack(1'b0);
                pulse_stop();
                tick(3);
                chk("R3 clear before sweep", 32'(flag_o), 32'h0);
                pin_i[p] = ~pin_i[p];
                tick(2);
                chk("R1 not yet after two edges", 32'(flag_o), 32'h0);
                tick(1);
                chk("R1 flag for port", 32'(flag_o), 32'(1 << p));
                chk("R1 irq with flag", 32'(irq_pull_o), 32'h1);
                pin_i[p] = ~pin_i[p];
                tick(4);
                chk("R2 flag stays", 32'(flag_o), 32'(1 << p));
            end
        end

        // R2: two-cycle pulse caught
        pin_i = 8'h00;
        tick(4);
        ack(1'b0);
        pulse_stop();
        pin_i[3] = 1'b1;
        tick(2);
        pin_i[3] = 1'b0;
        tick(5);
        chk("R2 short pulse flag", 32'(flag_o), 32'h08);

        // R3: ack reloads snapshot; held level not re-flagged
        pin_i = 8'h3C;
        tick(4);
        ack(1'b0);
        chk("R3 flags cleared", 32'(flag_o), 32'h0);
        chk("R3 irq released", 32'(irq_pull_o), 32'h0);
        pulse_stop();
        tick(4);
        chk("R3 held level not reflagged", 32'(flag_o), 32'h0);
        // write transfer does not suppress interrupt
        ack(1'b0);
        pin_i[0] = 1'b1;
        tick(3);
        chk("R4 write xfer irq allowed", 32'(irq_pull_o), 32'h1);
        pulse_stop();

        // R4/R5: change during read
        ack(1'b1);
        chk("R3 read ack clears irq", 32'(irq_pull_o), 32'h0);
        chk("R3 read ack clears flags", 32'(flag_o), 32'h0);
        pin_i[7] = 1'b1;
        tick(4);
        chk("R4 flag during read", 32'(flag_o), 32'h80);
        chk("R4 irq held off in read", 32'(irq_pull_o), 32'h0);
        pulse_stop();
        chk("R5 irq after stop", 32'(irq_pull_o), 32'h1);

        // R5: quiet read
        ack(1'b1);
        tick(4);
        pulse_stop();
        tick(2);
        chk("R5 quiet read no irq", 32'(irq_pull_o), 32'h0);
        chk("R5 quiet read no flag", 32'(flag_o), 32'h0);

        // R6: abort keeps asserted interrupt and flags
        pin_i[5] = ~pin_i[5];
        tick(3);
        chk("R1 irq before abort", 32'(irq_pull_o), 32'h1);
        bus_abort_i = 1'b1;
        tick();
        bus_abort_i = 1'b0;
        chk("R6 irq kept", 32'(irq_pull_o), 32'h1);
        chk("R6 flags kept", 32'(flag_o), 32'h20);
        // R6: abort during quiet read leaves irq released
        ack(1'b1);
        tick(2);
        bus_abort_i = 1'b1;
        tick();
        bus_abort_i = 1'b0;
        tick(2);
        chk("R6 abort quiet irq", 32'(irq_pull_o), 32'h0);
        chk("R6 abort quiet flags", 32'(flag_o), 32'h0);

        // R7: output write masks its own pin change
        ack(1'b0);
        pulse_stop();
        out_wr_i = 1'b1;
        tick();
        out_wr_i = 1'b0;
        pin_i = ~pin_i;
        tick(8);
        chk("R7 own write not flagged", 32'(flag_o), 32'h0);
        chk("R7 own write no irq", 32'(irq_pull_o), 32'h0);
        // monitoring resumes afterwards
        pin_i[1] = ~pin_i[1];
        tick(3);
        chk("R7 monitoring resumes", 32'(flag_o), 32'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule